// File: doc/BRIEF.md
# ATM Transmit Cell Framer

This block builds the byte stream of outgoing ATM cells for a byte-serial line interface. Each time the transmit scheduler grants a slot, the framer decides once, at the start of the slot, whether the slot carries a real cell or an idle cell. It then emits exactly 53 bytes under a valid/ready handshake. A real cell is made of four header bytes and 48 payload bytes pulled from an upstream byte source. The framer computes the header error check byte and inserts it between the header and the payload. If scrambling is enabled, the payload is scrambled on its way out.

An idle cell fills the slot when the scheduler has no channel to offer, when the offered channel has no buffer ready, or when the offered channel has been closed by a deactivate command. An idle cell carries a programmable header and a programmable fill byte. A starved channel yields an idle cell every time it is granted, and stops doing so only once its buffer is ready or it is closed. A small per-channel table holds the open/closed state, which is changed by activate and deactivate commands.

The control is a four-state machine. WAIT_SLOT waits for a grant. SEND_HDR sends the header bytes. SEND_HEC sends the check byte. SEND_PAY sends the payload. The transitions are slot_accept (WAIT_SLOT to SEND_HDR), hdr_done (SEND_HDR to SEND_HEC after the last header byte), hec_sent (SEND_HEC to SEND_PAY) and cell_done (SEND_PAY to WAIT_SLOT after the 48th payload byte). Every transition except slot_accept advances only on an accepted output byte.

Top module: `atm_tc_framer`

## Requirements
- R1: A slot granted with chan_valid=0 produces an idle cell. Its header bytes are cfg_idle_hdr with bits 31:24 first, and each of its 48 payload bytes is cfg_idle_pay before scrambling.
- R2: A slot granted with chan_valid=1 and buf_ready=0 produces an idle cell, and in_ready stays 0 for the whole cell. This repeats on every such grant.
- R3: A channel closed by cmd_valid=1, cmd_deact=1 yields idle cells even when buf_ready=1, until cmd_valid=1, cmd_deact=0 opens it again. All channels are open after reset.
- R4: A real cell (chan_valid=1, buf_ready=1, channel open) outputs 53 bytes. Bytes 0 to 3 are the first four source bytes, byte 4 is the check byte, and bytes 5 to 52 are the next 48 source bytes in order.
- R5: Byte 4 is the CRC-8 of header bytes 0 to 3 (generator x^8+x^2+x+1, register starting at zero, most significant bit first), XORed with 0x55. This holds for idle and real cells alike.
- R6: With cfg_scr_en=1, each payload bit is sent as the data bit XOR the bit sent 43 positions earlier, most significant bit of each byte first. Header and check bytes are never scrambled. With cfg_scr_en=0 the payload passes unchanged.
- R7: The scrambler history is not reset between cells. It advances only on scrambled payload bytes, so descrambling the concatenated payloads of successive cells recovers the data.
- R8: out_soc is 1 on byte 0 of every cell and 0 on every other byte.
- R9: Changes on chan_valid, buf_ready or the channel commands after slot_accept do not change the kind of the cell in progress.
- R10: While out_valid=1 and out_ready=0, the next cycle presents the same out_data. No byte is lost or repeated.
- R11: slot_take is 1 only when slot_req=1 in WAIT_SLOT. A request made during a cell is ignored. After reset out_valid, in_ready and slot_take are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | 1 | Scheduler grants a transmit slot |
| chan_valid | input | 1 | A channel is offered with the grant |
| chan_id | input | CHAN_W | Offered channel number |
| buf_ready | input | 1 | Offered channel has a cell buffered |
| cmd_valid | input | 1 | Channel command strobe |
| cmd_deact | input | 1 | 1 = close channel, 0 = open channel |
| cmd_chan | input | CHAN_W | Channel the command applies to |
| cfg_scr_en | input | 1 | Payload scrambling enable |
| cfg_idle_hdr | input | 8*HDR_BYTES | Idle cell header, first byte in the top bits |
| cfg_idle_pay | input | 8 | Idle cell payload fill byte |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Source byte taken this cycle |
| slot_take | output | 1 | Grant accepted this cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Line side accepts the byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is byte 0 of a cell |

## Verification
A wrong latched slot decision shows up at the ports within the first output cycle of the cell. The header bytes then differ from the idle pattern or from the source, and in_ready toggles when it should stay low. A corrupted check register shows up five bytes into the cell as a wrong byte 4. A wrong scrambler history shows up in the first payload byte after it is disturbed, because the bench keeps its own continuous descrambler across cells. A byte-counter error shows up as a cell whose length is not 53 or as out_soc on the wrong byte.

// File: rtl/atm_tcf_pkg.sv
`timescale 1ns/1ps
package atm_tcf_pkg;

    localparam int          SCR_LEN    = 43;       // self-synchronizing scrambler span
    localparam logic [7:0]  HEC_POLY   = 8'h07;    // x^8 + x^2 + x + 1 without the x^8 term
    localparam logic [7:0]  HEC_COSET  = 8'h55;

    typedef enum logic [1:0] {
        WAIT_SLOT = 2'd0,
        SEND_HDR  = 2'd1,
        SEND_HEC  = 2'd2,
        SEND_PAY  = 2'd3
    } tcf_state_e;

    typedef struct packed {
        logic [SCR_LEN-1:0] hist;
        logic [7:0]         q;
    } scr_res_t;

    // One byte through the CRC-8 register, MSB first.
    function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction

    // One byte through the x^43+1 scrambler, MSB first.
    function automatic scr_res_t scr_byte(input logic [SCR_LEN-1:0] hist, input logic [7:0] d);
        scr_res_t r;
        logic     b;
        r.hist = hist;
        r.q    = '0;
        for (int i = 7; i >= 0; i--) begin
            b      = d[i] ^ r.hist[SCR_LEN-1];
            r.q[i] = b;
            r.hist = {r.hist[SCR_LEN-2:0], b};
        end
        return r;
    endfunction

endpackage

// File: rtl/atm_tcf_hec.sv
`timescale 1ns/1ps
module atm_tcf_hec
    import atm_tcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] hec
);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= hec_step(crc_q, din);
        end
    end

    assign hec = crc_q ^ HEC_COSET;

    // R5: a fresh cell starts from a zero register, which reads as the coset alone
    p_fresh_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hec == HEC_COSET));

    // R5: the register holds between header bytes
    p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(hec));

endmodule

// File: rtl/atm_tcf_scr.sv
`timescale 1ns/1ps
module atm_tcf_scr
    import atm_tcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    logic [SCR_LEN-1:0] hist_q;
    scr_res_t           res;

    always_comb begin
        res  = scr_byte(hist_q, din);
        dout = res.q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (en) begin
            hist_q <= res.hist;
        end
    end

    // R7: history is kept across cells and idle stretches
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(hist_q));

    // R6: the newest history bits are the scrambled byte just sent
    p_self_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (hist_q[7:0] == $past(dout)));

endmodule

// File: rtl/atm_tcf_chan_tbl.sv
`timescale 1ns/1ps
module atm_tcf_chan_tbl #(
    parameter int NUM_CHAN = 4,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_deact,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [CHAN_W-1:0] look_chan,
    output logic              look_open
);

    logic [NUM_CHAN-1:0] open_q;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[g] <= 1'b1;
            end else if (cmd_valid && (cmd_chan == CHAN_W'(g))) begin
                open_q[g] <= !cmd_deact;
            end
        end

        // R3: a close command takes effect on the next cycle
        p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_deact && (cmd_chan == CHAN_W'(g))) |=> !open_q[g]);

        // R3: without a command for this channel its state does not move
        p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(cmd_valid && (cmd_chan == CHAN_W'(g))) |=> $stable(open_q[g]));
    end

    always_comb begin
        look_open = 1'b0;
        for (int i = 0; i < NUM_CHAN; i++) begin
            if (look_chan == CHAN_W'(i)) begin
                look_open = open_q[i];
            end
        end
    end

endmodule

// File: rtl/atm_tcf_fsm.sv
`timescale 1ns/1ps
module atm_tcf_fsm
    import atm_tcf_pkg::*;
#(
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48,
    localparam int MAXB     = (HDR_BYTES > PAY_BYTES) ? HDR_BYTES : PAY_BYTES,
    localparam int CNT_W    = $clog2(MAXB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_req,
    input  logic             want_data,
    input  logic             fire,
    output tcf_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             is_data,
    output logic             slot_take,
    output logic             hec_clr
);

    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAY_BYTES - 1);

    tcf_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             data_q, data_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WAIT_SLOT;
            cnt_q  <= '0;
            data_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            data_q <= data_d;
        end
    end

    // transitions: slot_accept, hdr_done, hec_sent, cell_done
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        data_d = data_q;
        unique case (st_q)
            WAIT_SLOT: begin
                if (slot_req) begin
                    st_d   = SEND_HDR;
                    cnt_d  = '0;
                    data_d = want_data;
                end
            end
            SEND_HDR: begin
                if (fire) begin
                    if (cnt_q == HDR_LAST) begin
                        st_d  = SEND_HEC;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SEND_HEC: begin
                if (fire) begin
                    st_d  = SEND_PAY;
                    cnt_d = '0;
                end
            end
            SEND_PAY: begin
                if (fire) begin
                    if (cnt_q == PAY_LAST) begin
                        st_d  = WAIT_SLOT;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = WAIT_SLOT;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state     = st_q;
        cnt       = cnt_q;
        is_data   = data_q;
        slot_take = (st_q == WAIT_SLOT) && slot_req;
        hec_clr   = slot_take;
    end

    // R9: the slot decision holds for the whole cell
    p_decision_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != WAIT_SLOT && $past(st_q) != WAIT_SLOT) |-> $stable(data_q));

    // R11: a grant is taken at most once before the cell starts
    p_take_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_take |=> !slot_take);

    // R4: a stalled byte leaves the position unchanged
    p_no_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && st_q != WAIT_SLOT) |=> ($stable(cnt_q) && $stable(st_q)));

endmodule

// File: rtl/atm_tc_framer.sv
`timescale 1ns/1ps
module atm_tc_framer
    import atm_tcf_pkg::*;
#(
    parameter int NUM_CHAN  = 4,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48,
    localparam int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int HDR_W    = 8 * HDR_BYTES,
    localparam int MAXB     = (HDR_BYTES > PAY_BYTES) ? HDR_BYTES : PAY_BYTES,
    localparam int CNT_W    = $clog2(MAXB),
    localparam int CELL_B   = HDR_BYTES + 1 + PAY_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_req,
    input  logic              chan_valid,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic              buf_ready,
    input  logic              cmd_valid,
    input  logic              cmd_deact,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              cfg_scr_en,
    input  logic [HDR_W-1:0]  cfg_idle_hdr,
    input  logic [7:0]        cfg_idle_pay,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              slot_take,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_soc
);

    tcf_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             is_data;
    logic             chan_open;
    logic             want_data;
    logic             fire;
    logic             hec_clr;
    logic [7:0]       hec_byte;
    logic [7:0]       idle_hdr_byte;
    logic [7:0]       hdr_byte;
    logic [7:0]       pay_raw;
    logic [7:0]       pay_scr;
    logic             scr_adv;

    atm_tcf_chan_tbl #(.NUM_CHAN(NUM_CHAN)) u_chan_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_deact (cmd_deact),
        .cmd_chan  (cmd_chan),
        .look_chan (chan_id),
        .look_open (chan_open)
    );

    assign want_data = chan_valid && buf_ready && chan_open;

    atm_tcf_fsm #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_req  (slot_req),
        .want_data (want_data),
        .fire      (fire),
        .state     (state),
        .cnt       (cnt),
        .is_data   (is_data),
        .slot_take (slot_take),
        .hec_clr   (hec_clr)
    );

    // idle header byte for the current position, first byte in the top bits
    always_comb begin
        idle_hdr_byte = '0;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (cnt == CNT_W'(i)) begin
                idle_hdr_byte = cfg_idle_hdr[8*(HDR_BYTES-1-i) +: 8];
            end
        end
    end

    assign hdr_byte = is_data ? in_data : idle_hdr_byte;
    assign pay_raw  = is_data ? in_data : cfg_idle_pay;

    atm_tcf_hec u_hec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hec_clr),
        .en    (fire && (state == SEND_HDR)),
        .din   (hdr_byte),
        .hec   (hec_byte)
    );

    assign scr_adv = fire && (state == SEND_PAY) && cfg_scr_en;

    atm_tcf_scr u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (scr_adv),
        .din   (pay_raw),
        .dout  (pay_scr)
    );

    // output mux
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_soc   = 1'b0;
        in_ready  = 1'b0;
        unique case (state)
            WAIT_SLOT: begin
                out_valid = 1'b0;
            end
            SEND_HDR: begin
                out_valid = is_data ? in_valid : 1'b1;
                out_data  = hdr_byte;
                out_soc   = (cnt == '0);
                in_ready  = is_data && out_ready;
            end
            SEND_HEC: begin
                out_valid = 1'b1;
                out_data  = hec_byte;
            end
            SEND_PAY: begin
                out_valid = is_data ? in_valid : 1'b1;
                out_data  = cfg_scr_en ? pay_scr : pay_raw;
                in_ready  = is_data && out_ready;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign fire = out_valid && out_ready;

    // length checker for R4 and R8
    logic [7:0] chk_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_len_q <= '0;
        end else if (fire) begin
            chk_len_q <= out_soc ? 8'd1 : chk_len_q + 8'd1;
        end
    end

    // R4: every cell before a new one has exactly CELL_B bytes
    p_cell_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_soc) |-> (chk_len_q == 8'd0 || chk_len_q == 8'(CELL_B)));

    // R8: the start marker never appears twice in a row of accepted bytes
    p_soc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_soc) |=> !out_soc);

    // R2: an idle cell never pulls source bytes
    p_no_pull_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_data || state == WAIT_SLOT) |-> !in_ready);

    // R10: an idle byte that is held back stays on the output
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !is_data) |=> (out_valid && $stable(out_data)));

    // R11: no byte is offered between cells
    p_quiet_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_SLOT) |-> !out_valid);

endmodule

// File: tb/atm_tc_framer_tb.sv
`timescale 1ns/1ps
module atm_tc_framer_tb;

    localparam int NCH  = 4;
    localparam int CW   = 2;
    localparam int NB   = 53;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_req = 1'b0;
    logic          chan_valid = 1'b0;
    logic [CW-1:0] chan_id = '0;
    logic          buf_ready = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_deact = 1'b0;
    logic [CW-1:0] cmd_chan = '0;
    logic          cfg_scr_en = 1'b0;
    logic [31:0]   cfg_idle_hdr = 32'h0000_0001;
    logic [7:0]    cfg_idle_pay = 8'h6A;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          slot_take;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_soc;

    int checks = 0;
    int fails  = 0;
    int cell_no = 0;
    bit finished = 1'b0;

    logic [42:0] m_scr  = '0;   // bench scrambler history
    logic [42:0] m_desc = '0;   // bench descrambler history

    always #2 clk = ~clk;       // 250 MHz

    atm_tc_framer #(.NUM_CHAN(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .chan_valid(chan_valid),
        .chan_id(chan_id), .buf_ready(buf_ready), .cmd_valid(cmd_valid),
        .cmd_deact(cmd_deact), .cmd_chan(cmd_chan), .cfg_scr_en(cfg_scr_en),
        .cfg_idle_hdr(cfg_idle_hdr), .cfg_idle_pay(cfg_idle_pay),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .slot_take(slot_take), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_soc(out_soc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cell %0d)", req, act, exp, cell_no);
        end
    endtask

    function automatic logic [7:0] m_crc(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        c = c_in ^ d;
        for (int k = 0; k < 8; k++) c = c[7] ? 8'((c << 1) ^ 8'h07) : 8'(c << 1);
        return c;
    endfunction

    task automatic send_cmd(input bit deact, input int ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_deact = deact; cmd_chan = CW'(ch);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_cell(input bit cv, input bit br, input int ch, input bit exp_data,
                            input bit stall, input bit gap, input bit perturb, input string tag);
        logic [7:0] src [52];
        logic [7:0] exp_b [NB];
        logic [7:0] raw_p [48];
        logic [7:0] got [NB];
        logic [7:0] crc;
        logic [7:0] prev_b;
        int  n, sidx, cyc;
        bit  prev_stall;
        int  pull_err, stall_err, soc_err, req_err;
        bit  b;
        cell_no++;
        for (int i = 0; i < 52; i++) src[i] = 8'(cell_no * 29 + i * 11 + 3);
        crc = '0;
        for (int i = 0; i < 4; i++) begin
            exp_b[i] = exp_data ? src[i] : cfg_idle_hdr[8*(3-i) +: 8];
            crc = m_crc(crc, exp_b[i]);
        end
        exp_b[4] = crc ^ 8'h55;
        for (int j = 0; j < 48; j++) begin
            raw_p[j] = exp_data ? src[4+j] : cfg_idle_pay;
            exp_b[5+j] = raw_p[j];
            if (cfg_scr_en) begin
                for (int k = 7; k >= 0; k--) begin
                    b = raw_p[j][k] ^ m_scr[42];
                    exp_b[5+j][k] = b;
                    m_scr = {m_scr[41:0], b};
                end
            end
        end
        // grant
        @(negedge clk);
        slot_req = 1'b1; chan_valid = cv; buf_ready = br; chan_id = CW'(ch);
        #1;
        check(slot_take == 1'b1, "R11 grant taken in WAIT_SLOT", slot_take, 1);
        @(posedge clk);
        n = 0; sidx = 0; cyc = 0; prev_stall = 0; prev_b = '0;
        pull_err = 0; stall_err = 0; soc_err = 0; req_err = 0;
        while (n < NB && cyc < 2000) begin
            @(negedge clk);
            slot_req = 1'b0;
            if (perturb) begin
                chan_valid = !cv; buf_ready = !br;
                cmd_valid = (cyc == 1); cmd_deact = 1'b1; cmd_chan = CW'(ch);
                slot_req = (cyc == 3);
            end
            out_ready = !(stall && (cyc % 3 == 1));
            in_valid  = !(gap && (cyc % 4 == 2));
            in_data   = (sidx < 52) ? src[sidx] : 8'h00;
            #1;
            if (slot_req && slot_take) req_err++;
            if (!exp_data && in_ready) pull_err++;
            if (out_valid) begin
                if (prev_stall && out_data != prev_b) stall_err++;
                if (out_soc != (n == 0)) soc_err++;
                if (out_ready) begin
                    got[n] = out_data;
                    n++;
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_b = out_data;
            if (in_ready && in_valid) sidx++;
            cyc++;
        end
        @(negedge clk);
        slot_req = 1'b0; cmd_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        check(n == NB, {tag, " R4 cell length"}, n, NB);
        if (n != NB) return;
        begin
            int bad_h, bad_p, bad_d;
            logic [7:0] dsc;
            bad_h = -1; bad_p = -1; bad_d = -1;
            for (int i = 0; i < 4; i++) if (bad_h < 0 && got[i] != exp_b[i]) bad_h = i;
            check(bad_h < 0, {tag, " R4 header bytes"}, (bad_h < 0) ? 0 : got[bad_h],
                  (bad_h < 0) ? 0 : exp_b[bad_h]);
            check(got[4] == exp_b[4], {tag, " R5 check byte"}, got[4], exp_b[4]);
            for (int j = 5; j < NB; j++) if (bad_p < 0 && got[j] != exp_b[j]) bad_p = j;
            check(bad_p < 0, {tag, " R6 payload bytes"}, (bad_p < 0) ? 0 : got[bad_p],
                  (bad_p < 0) ? 0 : exp_b[bad_p]);
            if (cfg_scr_en) begin
                for (int j = 0; j < 48; j++) begin
                    for (int k = 7; k >= 0; k--) begin
                        dsc[k] = got[5+j][k] ^ m_desc[42];
                        m_desc = {m_desc[41:0], got[5+j][k]};
                    end
                    if (bad_d < 0 && dsc != raw_p[j]) bad_d = j;
                end
                check(bad_d < 0, {tag, " R7 continuous descramble"}, bad_d, -1);
            end
            check(sidx == (exp_data ? 52 : 0), {tag, " R2 source bytes pulled"}, sidx,
                  exp_data ? 52 : 0);
            check(pull_err == 0, {tag, " R2 in_ready during idle cell"}, pull_err, 0);
            check(soc_err == 0, {tag, " R8 start marker placement"}, soc_err, 0);
            if (stall) check(stall_err == 0, {tag, " R10 held byte under stall"}, stall_err, 0);
            if (perturb) check(req_err == 0, {tag, " R11 mid-cell request ignored"}, req_err, 0);
        end
        if (perturb) send_cmd(1'b0, ch);   // reopen channel closed mid-cell
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
        check(in_ready == 1'b0, "R11 reset in_ready", in_ready, 0);
        check(slot_take == 1'b0, "R11 reset slot_take", slot_take, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // sweep over scrambling, line stalls and source gaps
        for (int s = 0; s < 2; s++) begin
            for (int st = 0; st < 2; st++) begin
                for (int g = 0; g < 2; g++) begin
                    cfg_scr_en = s[0];
                    run_cell(1'b0, 1'b1, 0, 1'b0, st[0], g[0], 1'b0, "R1 empty queue");
                    run_cell(1'b1, 1'b0, 1, 1'b0, st[0], g[0], 1'b0, "R2 no buffer");
                    run_cell(1'b1, 1'b0, 1, 1'b0, st[0], g[0], 1'b0, "R2 no buffer again");
                    run_cell(1'b1, 1'b1, (s*4+st*2+g) % NCH, 1'b1, st[0], g[0], 1'b0, "R4 real cell");
                    run_cell(1'b1, 1'b1, 3, 1'b1, st[0], g[0], 1'b1, "R9 inputs flip mid-cell");
                    run_cell(1'b0, 1'b0, 2, 1'b0, st[0], g[0], 1'b1, "R9 idle held mid-cell");
                end
            end
        end

        // channel close and reopen
        cfg_scr_en = 1'b1;
        send_cmd(1'b1, 2);
        run_cell(1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R3 closed channel");
        run_cell(1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 other channel open");
        run_cell(1'b1, 1'b1, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R3 still closed");
        send_cmd(1'b0, 2);
        run_cell(1'b1, 1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reopened");

        // other idle pattern, scrambler pausing and resuming
        cfg_idle_hdr = 32'hA5C3_0F96; cfg_idle_pay = 8'h00;
        run_cell(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 new idle pattern");
        cfg_scr_en = 1'b0;
        run_cell(1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 scrambler off");
        cfg_scr_en = 1'b1;
        run_cell(1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 scrambler resumes");
        cfg_idle_hdr = 32'hFFFF_FFFF; cfg_idle_pay = 8'hFF;
        run_cell(1'b0, 1'b1, 3, 1'b0, 1'b1, 1'b1, 1'b0, "R5 all-ones header");

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule